// File: doc/BRIEF.md
# Synchronous Byte-Lane Memory Core with Selectable Read Latency

This block is a behavioural synchronous memory core. On each rising clock edge it registers an address, a chip enable, the write controls and the write data. A registered write updates the array one edge later. It can write only the byte lanes picked by active-low lane selects, or it can write all lanes at once through a global write.

Read data leaves the core in one of two timings. In flow-through mode the word read from the array goes straight to the output in the cycle after the read is captured. In pipelined mode an extra output register adds one cycle. Whether the output is driven is reported on a drive-enable port, and the data port reads zero whenever it is not driven.

A deselect turns the output off as early as the selected timing allows. A write never drives the output, and it blocks any pipelined read data that is still leaving. An asynchronous output enable gates the drive at once. A sleep input blocks all new operations and turns the output off, and the stored words are kept.

Top module: `sram_core`

## Requirements
- R1: While reset is high and after it is released with no operation issued, `rdrive` is 0 and `rdata` is 0.
- R2: With `pipe_mode` = 0, a read captured at edge E drives the word at its address on `rdata` with `rdrive` = 1 in the cycle that follows E.
- R3: With `pipe_mode` = 1, a read captured at edge E is driven in the cycle that follows edge E+1. If the operation before it was not a read, the output is not driven in the cycle that follows E.
- R4: A deselect (`chip_en` = 0) captured at edge D turns the output off right after D in flow-through mode, and after D+1 in pipelined mode.
- R5: With `chip_en` = 1, `wr_all` = 0 and `wr_byte` = 1, only the lanes i with `lane_sel_n[i]` = 0 are written. Lane i is bits [i*LANE_W +: LANE_W] of `wdata`, and the other lanes keep their contents.
- R6: With `chip_en` = 1 and `wr_all` = 1, every lane is written, whatever the values of `wr_byte` and `lane_sel_n`.
- R7: A byte write with every `lane_sel_n` bit at 1 changes no lane and drives no output.
- R8: A captured write never drives the output. In pipelined mode, a read followed directly by a write is not driven in the cycle after the write is captured.
- R9: `out_en` = 0 forces `rdrive` = 0 and `rdata` = 0 at once, with no clock edge needed.
- R10: While `sleep` = 1, captured reads and writes have no effect, the output stays off, and the stored words survive.
- R11: A read captured on the edge directly after a write to the same address returns the newly written lanes.
- R12: Back-to-back reads deliver one word per cycle in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 0 = flow-through, 1 = pipelined output |
| chip_en | input | 1 | Operation select; 0 = deselect |
| wr_all | input | 1 | Global write of every lane |
| wr_byte | input | 1 | Byte-write enable |
| lane_sel_n | input | LANES | Active-low per-lane write select |
| addr | input | $clog2(DEPTH) | Word address |
| wdata | input | LANES*LANE_W | Write data, lane i at bits [i*LANE_W +: LANE_W] |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Low-power hold; blocks operations |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdrive | output | 1 | High while the output is driven |

## Verification
The assertions assume that `pipe_mode` only changes after at least one idle cycle, and that `sleep` and `out_en` only change between edges. The stimulus changes the mode only after a run of deselects. It drives every input at the falling edge, so each input is stable at the rising edge that samples it. Every read targets an address that was written earlier, so no check ever depends on uninitialised array contents.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int LANES_DEF  = 2;
    localparam int LANE_W_DEF = 9;
    localparam int DEPTH_DEF  = 16;

    // Sleep and deselect both yield an idle slot; any write control makes a write.
    function automatic op_e decode_op(input logic ce, input logic slp,
                                      input logic all_wr, input logic byte_wr);
        if (slp || !ce)          return OP_IDLE;
        if (all_wr || byte_wr)   return OP_WRITE;
        return OP_READ;
    endfunction

endpackage

// File: rtl/sram_cmd_stage.sv
module sram_cmd_stage
    import sram_core_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    parameter int AW     = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic                    sleep,
    input  logic                    wr_all,
    input  logic                    wr_byte,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic [AW-1:0]           addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output op_e                     op_o,
    output logic [AW-1:0]           addr_o,
    output logic [LANES-1:0]        lanes_o,
    output logic [LANES*LANE_W-1:0] wdata_o
);
    localparam int W = LANES * LANE_W;

    typedef struct packed {
        op_e              op;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] lanes;
        logic [W-1:0]     data;
    } cmd_t;

    cmd_t cmd_q, cmd_d;

    always_comb begin
        cmd_d.op    = decode_op(ce, sleep, wr_all, wr_byte);
        cmd_d.addr  = addr_i;
        cmd_d.data  = wdata_i;
        if (wr_all)
            cmd_d.lanes = '1;
        else if (wr_byte)
            cmd_d.lanes = ~lane_sel_n;
        else
            cmd_d.lanes = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '{op: OP_IDLE, addr: '0, lanes: '0, data: '0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign op_o    = cmd_q.op;
    assign addr_o  = cmd_q.addr;
    assign lanes_o = cmd_q.lanes;
    assign wdata_o = cmd_q.data;

    assert_sleep_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (op_o == OP_IDLE));

    assert_global_all_lanes_R6: assert property (@(posedge clk) disable iff (rst)
        (ce && wr_all && !sleep) |=> (op_o == OP_WRITE && lanes_o == '1));

    assert_byte_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        (ce && !wr_all && wr_byte && !sleep) |=> (lanes_o == ~$past(lane_sel_n)));

endmodule

// File: rtl/sram_array.sv
module sram_array
    import sram_core_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    parameter int DEPTH  = DEPTH_DEF,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  op_e                     op,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        lanes,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (op == OP_WRITE && lanes[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_o[g*LANE_W +: LANE_W] = mem[addr];
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_core_pkg::*;
#(
    parameter int W = LANES_DEF * LANE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pipe_mode,
    input  logic         oe,
    input  logic         sleep,
    input  op_e          op,
    input  logic [W-1:0] rd_i,
    output logic [W-1:0] rdata,
    output logic         rdrive
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } pipe_t;

    pipe_t pipe_q;
    logic  want_drive;
    logic  [W-1:0] sel_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '{valid: 1'b0, data: '0};
        end else begin
            pipe_q.valid <= (op == OP_READ);
            if (op == OP_READ)
                pipe_q.data <= rd_i;
        end
    end

    always_comb begin
        if (pipe_mode) begin
            want_drive = pipe_q.valid && (op != OP_WRITE);
            sel_data   = pipe_q.data;
        end else begin
            want_drive = (op == OP_READ);
            sel_data   = rd_i;
        end
    end

    assign rdrive = want_drive && oe && !sleep;
    assign rdata  = rdrive ? sel_data : '0;

    assert_write_never_drives_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |-> !rdrive);

    assert_oe_gates_R9: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (!rdrive && rdata == '0));

    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !rdrive);

    assert_flow_deselect_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && op != OP_READ) |-> !rdrive);

    assert_pipe_deselect_off_R4: assert property (@(posedge clk) disable iff (rst)
        (op != OP_READ) |=> !(pipe_mode && rdrive));

endmodule

// File: rtl/sram_core.sv
module sram_core
    import sram_core_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    parameter int DEPTH  = DEPTH_DEF,
    localparam int W     = LANES * LANE_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pipe_mode,
    input  logic             chip_en,
    input  logic             wr_all,
    input  logic             wr_byte,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wdata,
    input  logic             out_en,
    input  logic             sleep,
    output logic [W-1:0]     rdata,
    output logic             rdrive
);
    op_e              c_op;
    logic [AW-1:0]    c_addr;
    logic [LANES-1:0] c_lanes;
    logic [W-1:0]     c_wdata;
    logic [W-1:0]     arr_rd;

    sram_cmd_stage #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_cmd (
        .clk(clk), .rst(rst), .ce(chip_en), .sleep(sleep),
        .wr_all(wr_all), .wr_byte(wr_byte), .lane_sel_n(lane_sel_n),
        .addr_i(addr), .wdata_i(wdata),
        .op_o(c_op), .addr_o(c_addr), .lanes_o(c_lanes), .wdata_o(c_wdata)
    );

    sram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH), .AW(AW)) u_arr (
        .clk(clk), .op(c_op), .addr(c_addr), .lanes(c_lanes),
        .wdata(c_wdata), .rd_o(arr_rd)
    );

    sram_out_stage #(.W(W)) u_out (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .oe(out_en),
        .sleep(sleep), .op(c_op), .rd_i(arr_rd),
        .rdata(rdata), .rdrive(rdrive)
    );

endmodule

// File: tb/tb_sram_core.sv
module tb_sram_core;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int DEPTH  = 16;
    localparam int W      = LANES * LANE_W;
    localparam int AW     = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pipe_mode = 1'b0;
    logic             chip_en = 1'b0;
    logic             wr_all = 1'b0;
    logic             wr_byte = 1'b0;
    logic [LANES-1:0] lane_sel_n = '1;
    logic [AW-1:0]    addr = '0;
    logic [W-1:0]     wdata = '0;
    logic             out_en = 1'b1;
    logic             sleep = 1'b0;
    logic [W-1:0]     rdata;
    logic             rdrive;

    sram_core #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .chip_en(chip_en),
        .wr_all(wr_all), .wr_byte(wr_byte), .lane_sel_n(lane_sel_n),
        .addr(addr), .wdata(wdata), .out_en(out_en), .sleep(sleep),
        .rdata(rdata), .rdrive(rdrive)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic         drv;
        logic [W-1:0] data;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state built from the requirements
    logic [W-1:0]     m_mem [DEPTH];
    int               p_op = 0;          // 0 idle, 1 read, 2 write
    logic [AW-1:0]    p_addr = '0;
    logic [LANES-1:0] p_lanes = '0;
    logic [W-1:0]     p_data = '0;

    task automatic check(input string tag, input logic dv, input logic [W-1:0] dd);
        n_cmp++;
        if (rdrive !== dv || rdata !== dd) begin
            n_bad++;
            $display("FAIL %s: actual drive=%0b data=%h expected drive=%0b data=%h",
                     tag, rdrive, rdata, dv, dd);
        end
    endtask

    // Driver: one operation per cycle, expected output queued for the monitor
    task automatic cyc(input logic ce, input logic wa, input logic wb,
                       input logic [LANES-1:0] seln, input logic [AW-1:0] a,
                       input logic [W-1:0] wd, input string tag);
        int            nop;
        logic          q_read;
        logic [W-1:0]  q_data;
        exp_t          e;
        @(negedge clk);
        chip_en = ce; wr_all = wa; wr_byte = wb; lane_sel_n = seln;
        addr = a; wdata = wd;
        q_read = (p_op == 1);
        q_data = m_mem[p_addr];
        if (p_op == 2)
            for (int i = 0; i < LANES; i++)
                if (p_lanes[i]) m_mem[p_addr][i*LANE_W +: LANE_W] = p_data[i*LANE_W +: LANE_W];
        if (sleep || !ce)   nop = 0;
        else if (wa || wb)  nop = 2;
        else                nop = 1;
        p_op = nop; p_addr = a; p_data = wd;
        p_lanes = wa ? '1 : (wb ? ~seln : '0);
        if (pipe_mode) begin
            e.drv  = q_read && (nop != 2);
            e.data = q_data;
        end else begin
            e.drv  = (nop == 1);
            e.data = m_mem[a];
        end
        e.drv = e.drv && out_en && !sleep;
        if (!e.drv) e.data = '0;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        cyc(1'b1, 1'b0, 1'b0, '1, a, '0, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, 1'b0, '1, '0, '0, tag);
    endtask

    // Monitor: compares after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, e.drv, e.data);
        end
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #2 check("R1 in reset", 1'b0, '0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2 check("R1 after reset", 1'b0, '0);

        // Flow-through mode
        cyc(1, 1, 0, '1, 4'd1, 18'h3ABCD, "R8 global write flow");
        rd(4'd1, "R11 R2 read after write");
        cyc(1, 0, 1, 2'b10, 4'd1, 18'h155AA, "R8 byte write lane0");
        rd(4'd1, "R5 lane0 only");
        cyc(1, 0, 1, 2'b11, 4'd1, 18'h3FFFF, "R7 no lanes selected");
        rd(4'd1, "R7 contents unchanged");
        cyc(1, 0, 1, 2'b01, 4'd2, 18'h12345, "R5 byte write lane1 new addr");
        cyc(1, 1, 1, 2'b11, 4'd2, 18'h2F0F0, "R6 global overrides selects");
        rd(4'd2, "R6 all lanes written");
        rd(4'd1, "R12 back-to-back flow");
        rd(4'd2, "R12 back-to-back flow");
        idle("R4 flow deselect off");
        rd(4'd1, "R2 read before oe test");
        @(posedge clk); #3 out_en = 1'b0;
        #1 check("R9 async oe low", 1'b0, '0);
        out_en = 1'b1;
        @(negedge clk); out_en = 1'b0;
        rd(4'd1, "R9 oe low read");
        @(negedge clk); out_en = 1'b1;
        rd(4'd2, "R2 oe restored");

        // Sleep
        @(negedge clk); sleep = 1'b1;
        cyc(1, 1, 0, '1, 4'd1, 18'h00001, "R10 write ignored in sleep");
        rd(4'd1, "R10 read blocked in sleep");
        @(negedge clk); sleep = 1'b0;
        rd(4'd1, "R10 contents kept");
        idle("R4 idle before mode change");
        idle("R4 idle before mode change");

        // Pipelined mode
        @(negedge clk); pipe_mode = 1'b1;
        rd(4'd1, "R3 no data first cycle");
        rd(4'd2, "R3 R12 first word");
        rd(4'd1, "R12 second word");
        idle("R4 deselect still shows last read");
        idle("R4 pipe deselect off");
        rd(4'd2, "R3 lead cycle");
        cyc(1, 1, 0, '1, 4'd3, 18'h0ACE1, "R8 write blocks pipelined data");
        idle("R8 after write");
        rd(4'd3, "R11 pipelined read of new word");
        idle("R3 pipelined data out");
        idle("R4 final off");
        repeat (3) @(posedge clk);
        #3;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule